// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits beside the fetch stage of a 32-bit embedded RISC core and turns an exception request into a control-flow change. Each request carries a cause code, a small error subcode, the address of the next instruction and the machine state word the core holds. In one clock the sequencer picks a return address for the cause and stores it with a filtered copy of the state word in one of two save pairs. It forms the state word the handler will run under and sends a one-cycle redirect to the handler address. That address is the entry for the cause in a programmable vector table, ORed with a base address.

The same block also runs the two return-from-interrupt flavours. A normal return reloads address and state from the normal pair. A critical return reloads them from the critical pair under a tighter mask. The core owns its state register and loads `msr_out` whenever `msr_we` pulses. The save registers live here and are visible as outputs.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `redir_valid`, `msr_we`, `checkstop`, `vec_err` and all four save-register outputs are zero.
- R2: An accepted request gives, on the following clock, a one-cycle `redir_valid` and `msr_we` pulse. `redir_addr` is the vector-table entry for `req_cause` ORed with `vec_base`.
- R3: The saved return address is `cur_nia - 4` for alignment (6), program (7), FP-unavailable (8), auxiliary-unavailable (10) and vector-unavailable (16). It is `cur_nia` for every other cause, and also for an FP program exception with FE0 (bit 11) and FE1 (bit 8) both set.
- R4: The saved state word is `cur_msr` with mask 0x783F0000 cleared, then ORed with cause bits. For program cause 7 these are: `req_code`=0 (FP) 0x00100000, plus 0x00010000 when FE0 differs from FE1; code 1 (illegal) 0x00080000; code 2 (privileged) 0x00040000; code 3 (trap) 0x00020000.
- R5: The new state word is zero except for machine-check-enable (bit 12), copied from `cur_msr`, and little-endian (bit 0), set when interrupt-little-endian (bit 16) of `cur_msr` is set.
- R6: An FP program exception is dropped when FP-available (bit 13) is 0 or FE0 and FE1 are both 0. A dropped exception gives no redirect and changes no save register.
- R7: Critical input (2) and watchdog (13) write the critical pair. All other causes write the normal pair. The pair not written keeps its value.
- R8: A machine check (1) clears machine-check-enable in the new state word. If bit 12 of `cur_msr` is 0, `checkstop` sets instead and stays set until reset. While it is set, no request or return has any effect.
- R9: On system reset cause (0), power-save (bit 18) set ORs 0x00010000 into the saved state. Power-save clear instead clears machine-check-enable in the new state word.
- R10: A normal return redirects to the normal saved address with its low 2 bits cleared. It loads the normal saved state ANDed with ~0x783F0000.
- R11: A critical return redirects to the critical saved address with its low 2 bits cleared. It loads the critical saved state ANDed with 0x0000FFFF.
- R12: A request whose vector entry is all ones, or was never written, sets sticky `vec_err` with no redirect and no save-register change. Later valid requests still redirect.
- R13: When a request and a return arrive in the same cycle, the request is taken and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request strobe |
| req_cause | input | 5 | Exception cause code |
| req_code | input | 2 | Error subcode (program exception kind) |
| cur_nia | input | XLEN | Address of the next instruction |
| cur_msr | input | XLEN | Current machine state word |
| ret_valid | input | 1 | Return-from-interrupt strobe |
| ret_crit | input | 1 | Return uses the critical pair |
| vec_base | input | XLEN | Base ORed into every handler address |
| vec_we | input | 1 | Vector table write enable |
| vec_idx | input | 5 | Vector table write index (cause) |
| vec_wdata | input | XLEN | Vector table write data |
| redir_valid | output | 1 | One-cycle redirect to fetch |
| redir_addr | output | XLEN | Redirect target address |
| msr_we | output | 1 | Load strobe for the core state word |
| msr_out | output | XLEN | New state word |
| nrm_ret_addr | output | XLEN | Normal pair saved address |
| nrm_ret_state | output | XLEN | Normal pair saved state |
| crt_ret_addr | output | XLEN | Critical pair saved address |
| crt_ret_state | output | XLEN | Critical pair saved state |
| checkstop | output | 1 | Sticky checkstop flag |
| vec_err | output | 1 | Sticky missing-vector flag |

## Verification
The main stimulus is a table of entries that walks the causes across different state words. The all-ones word tells the clear mask apart from the kept bits. Single-bit words separate the copy of machine-check-enable from the set of little-endian. Each program subcode shows its own saved bit and the choice between faulting and next address. Critical and watchdog rows show that the normal pair stays unchanged, which catches a wrong pair select. Directed cases then try the FP drop conditions, both return masks after a non-aligned saved address, a same-cycle request and return, a missing vector, and a machine check with enable clear followed by traffic that must have no effect.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int CAUSE_BITS = 5;
  localparam int CODE_BITS  = 2;

  typedef enum logic [CAUSE_BITS-1:0] {
    C_SYSRST  = 5'd0,
    C_MCHK    = 5'd1,
    C_CRIT    = 5'd2,
    C_DSTOR   = 5'd3,
    C_ISTOR   = 5'd4,
    C_EXTIN   = 5'd5,
    C_ALIGN   = 5'd6,
    C_PROG    = 5'd7,
    C_FPUNAV  = 5'd8,
    C_SYSCALL = 5'd9,
    C_AUXNAV  = 5'd10,
    C_DECR    = 5'd11,
    C_FIXTMR  = 5'd12,
    C_WDOG    = 5'd13,
    C_DTLB    = 5'd14,
    C_ITLB    = 5'd15,
    C_VECNAV  = 5'd16,
    C_PITMR   = 5'd17
  } exc_cause_e;

  // program exception kinds carried in the subcode
  localparam logic [CODE_BITS-1:0] PK_FP   = 2'd0;
  localparam logic [CODE_BITS-1:0] PK_ILL  = 2'd1;
  localparam logic [CODE_BITS-1:0] PK_PRIV = 2'd2;
  localparam logic [CODE_BITS-1:0] PK_TRAP = 2'd3;

  // state word bit positions
  localparam int SB_LE  = 0;
  localparam int SB_FE1 = 8;
  localparam int SB_FE0 = 11;
  localparam int SB_ME  = 12;
  localparam int SB_FP  = 13;
  localparam int SB_ILE = 16;
  localparam int SB_POW = 18;

  // saved-state cause bits
  localparam int SV_FPEN  = 20;
  localparam int SV_ILL   = 19;
  localparam int SV_PRIV  = 18;
  localparam int SV_TRAP  = 17;
  localparam int SV_AUX16 = 16;

  localparam logic [63:0] SAVE_CLR_MASK = 64'h0000_0000_783F_0000;
  localparam logic [63:0] CRIT_KEEP     = 64'h0000_0000_0000_FFFF;

endpackage

// File: rtl/exc_vec_table.sv
module exc_vec_table
  import exc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [CAUSE_BITS-1:0] wr_idx,
  input  logic [XLEN-1:0]       wr_data,
  input  logic [CAUSE_BITS-1:0] rd_idx,
  output logic [XLEN-1:0]       rd_vec,
  output logic                  rd_ok
);
  localparam int DEPTH = 1 << CAUSE_BITS;

  logic [XLEN-1:0] mem [DEPTH];
  logic [DEPTH-1:0] written_q;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) written_q <= '0;
    else if (wr_en) written_q[wr_idx] <= 1'b1;
  end

  assign rd_vec = mem[rd_idx];
  assign rd_ok  = written_q[rd_idx] && (rd_vec != {XLEN{1'b1}});

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [CAUSE_BITS-1:0] cause,
  input  logic [CODE_BITS-1:0]  code,
  input  logic [XLEN-1:0]       cur_msr,
  input  logic [XLEN-1:0]       cur_nia,
  output logic [XLEN-1:0]       save_addr,
  output logic [XLEN-1:0]       save_state,
  output logic [XLEN-1:0]       new_msr,
  output logic                  use_crit,
  output logic                  drop,
  output logic                  stop
);
  localparam logic [XLEN-1:0] CLR = SAVE_CLR_MASK[XLEN-1:0];

  logic [XLEN-1:0] extra;
  logic            faulting;
  logic            fe0, fe1, fpa;
  exc_cause_e      c;

  assign fe0 = cur_msr[SB_FE0];
  assign fe1 = cur_msr[SB_FE1];
  assign fpa = cur_msr[SB_FP];
  assign c   = exc_cause_e'(cause);

  always_comb begin
    extra             = '0;
    new_msr           = '0;
    new_msr[SB_ME]    = cur_msr[SB_ME];
    faulting          = 1'b0;
    use_crit          = 1'b0;
    drop              = 1'b0;
    stop              = 1'b0;
    case (c)
      C_SYSRST: begin
        if (cur_msr[SB_POW]) extra[SV_AUX16] = 1'b1;
        else                 new_msr[SB_ME]  = 1'b0;
      end
      C_MCHK: begin
        new_msr[SB_ME] = 1'b0;
        stop           = !cur_msr[SB_ME];
      end
      C_CRIT, C_WDOG: use_crit = 1'b1;
      C_ALIGN, C_FPUNAV, C_AUXNAV, C_VECNAV: faulting = 1'b1;
      C_PROG: begin
        faulting = 1'b1;
        case (code)
          PK_FP: begin
            if ((!fe0 && !fe1) || !fpa) begin
              drop = 1'b1;
            end else begin
              extra[SV_FPEN] = 1'b1;
              if (fe0 == fe1) faulting = 1'b0;
              else            extra[SV_AUX16] = 1'b1;
            end
          end
          PK_ILL:  extra[SV_ILL]  = 1'b1;
          PK_PRIV: extra[SV_PRIV] = 1'b1;
          default: extra[SV_TRAP] = 1'b1;
        endcase
      end
      default: ;
    endcase
    if (cur_msr[SB_ILE]) new_msr[SB_LE] = 1'b1;
  end

  assign save_state = (cur_msr & ~CLR) | extra;
  assign save_addr  = faulting ? (cur_nia - XLEN'(4)) : cur_nia;

endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank #(
  parameter int XLEN  = 32,
  parameter int PAIRS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(PAIRS)-1:0] wr_sel,
  input  logic [XLEN-1:0]          wr_addr,
  input  logic [XLEN-1:0]          wr_state,
  output logic [XLEN-1:0]          addr_q  [PAIRS],
  output logic [XLEN-1:0]          state_q [PAIRS]
);
  localparam int SEL_W = $clog2(PAIRS);

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[g]  <= '0;
        state_q[g] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        addr_q[g]  <= wr_addr;
        state_q[g] <= wr_state;
      end
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [CAUSE_BITS-1:0] req_cause,
  input  logic [CODE_BITS-1:0]  req_code,
  input  logic [XLEN-1:0]       cur_nia,
  input  logic [XLEN-1:0]       cur_msr,
  input  logic                  ret_valid,
  input  logic                  ret_crit,
  input  logic [XLEN-1:0]       vec_base,
  input  logic                  vec_we,
  input  logic [CAUSE_BITS-1:0] vec_idx,
  input  logic [XLEN-1:0]       vec_wdata,
  output logic                  redir_valid,
  output logic [XLEN-1:0]       redir_addr,
  output logic                  msr_we,
  output logic [XLEN-1:0]       msr_out,
  output logic [XLEN-1:0]       nrm_ret_addr,
  output logic [XLEN-1:0]       nrm_ret_state,
  output logic [XLEN-1:0]       crt_ret_addr,
  output logic [XLEN-1:0]       crt_ret_state,
  output logic                  checkstop,
  output logic                  vec_err
);
  localparam int PAIRS = 2;
  localparam logic [XLEN-1:0] CLR   = SAVE_CLR_MASK[XLEN-1:0];
  localparam logic [XLEN-1:0] CKEEP = CRIT_KEEP[XLEN-1:0];
  localparam logic [XLEN-1:0] WALGN = ~XLEN'(3);

  logic [XLEN-1:0] vt_vec;
  logic            vt_ok;
  logic [XLEN-1:0] ec_addr, ec_state, ec_newmsr;
  logic            ec_crit, ec_drop, ec_stop;
  logic [XLEN-1:0] sv_addr  [PAIRS];
  logic [XLEN-1:0] sv_state [PAIRS];
  logic            sv_we;

  logic            redir_valid_q, msr_we_q, checkstop_q, vec_err_q;
  logic [XLEN-1:0] redir_addr_q, msr_out_q;

  exc_vec_table #(.XLEN(XLEN)) vtab_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (vec_we),
    .wr_idx  (vec_idx),
    .wr_data (vec_wdata),
    .rd_idx  (req_cause),
    .rd_vec  (vt_vec),
    .rd_ok   (vt_ok)
  );

  exc_entry_calc #(.XLEN(XLEN)) calc_i (
    .cause      (req_cause),
    .code       (req_code),
    .cur_msr    (cur_msr),
    .cur_nia    (cur_nia),
    .save_addr  (ec_addr),
    .save_state (ec_state),
    .new_msr    (ec_newmsr),
    .use_crit   (ec_crit),
    .drop       (ec_drop),
    .stop       (ec_stop)
  );

  assign sv_we = !checkstop_q && req_valid && !ec_drop && !ec_stop && vt_ok;

  exc_save_bank #(.XLEN(XLEN), .PAIRS(PAIRS)) bank_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (sv_we),
    .wr_sel   (ec_crit),
    .wr_addr  (ec_addr),
    .wr_state (ec_state),
    .addr_q   (sv_addr),
    .state_q  (sv_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid_q <= 1'b0;
      redir_addr_q  <= '0;
      msr_we_q      <= 1'b0;
      msr_out_q     <= '0;
      checkstop_q   <= 1'b0;
      vec_err_q     <= 1'b0;
    end else begin
      redir_valid_q <= 1'b0;
      msr_we_q      <= 1'b0;
      if (!checkstop_q) begin
        if (req_valid) begin
          if (ec_drop) begin
            redir_valid_q <= 1'b0;
          end else if (ec_stop) begin
            checkstop_q <= 1'b1;
          end else if (!vt_ok) begin
            vec_err_q <= 1'b1;
          end else begin
            redir_valid_q <= 1'b1;
            redir_addr_q  <= vt_vec | vec_base;
            msr_we_q      <= 1'b1;
            msr_out_q     <= ec_newmsr;
          end
        end else if (ret_valid) begin
          redir_valid_q <= 1'b1;
          msr_we_q      <= 1'b1;
          if (ret_crit) begin
            redir_addr_q <= sv_addr[1] & WALGN;
            msr_out_q    <= sv_state[1] & CKEEP;
          end else begin
            redir_addr_q <= sv_addr[0] & WALGN;
            msr_out_q    <= sv_state[0] & ~CLR;
          end
        end
      end
    end
  end

  assign redir_valid   = redir_valid_q;
  assign redir_addr    = redir_addr_q;
  assign msr_we        = msr_we_q;
  assign msr_out       = msr_out_q;
  assign checkstop     = checkstop_q;
  assign vec_err       = vec_err_q;
  assign nrm_ret_addr  = sv_addr[0];
  assign nrm_ret_state = sv_state[0];
  assign crt_ret_addr  = sv_addr[1];
  assign crt_ret_state = sv_state[1];

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            ret_valid,
  input logic            ret_crit,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_addr,
  input logic            msr_we,
  input logic            checkstop,
  input logic            vec_err,
  input logic [XLEN-1:0] nrm_ret_addr,
  input logic [XLEN-1:0] crt_ret_addr,
  input logic [XLEN-1:0] nrm_ret_state,
  input logic [XLEN-1:0] crt_ret_state
);
  localparam logic [XLEN-1:0] WALGN = ~XLEN'(3);

  // R2
  redir_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> ($past(req_valid) || $past(ret_valid)));

  // R8
  checkstop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    checkstop |=> checkstop);

  // R8
  checkstop_silent_chk: assert property (@(posedge clk) disable iff (rst)
    checkstop |=> (!redir_valid && !msr_we));

  // R12
  vec_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    vec_err |=> vec_err);

  // R7
  save_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(nrm_ret_addr) && $stable(crt_ret_addr) &&
                    $stable(nrm_ret_state) && $stable(crt_ret_state)));

  // R10
  nrm_return_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !ret_crit && !req_valid && !checkstop) |=>
      (redir_valid && redir_addr == ($past(nrm_ret_addr) & WALGN)));

  // R11
  crt_return_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_crit && !req_valid && !checkstop) |=>
      (redir_valid && redir_addr == ($past(crt_ret_addr) & WALGN)));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .ret_valid     (ret_valid),
  .ret_crit      (ret_crit),
  .redir_valid   (redir_valid),
  .redir_addr    (redir_addr),
  .msr_we        (msr_we),
  .checkstop     (checkstop),
  .vec_err       (vec_err),
  .nrm_ret_addr  (nrm_ret_addr),
  .crt_ret_addr  (crt_ret_addr),
  .nrm_ret_state (nrm_ret_state),
  .crt_ret_state (crt_ret_state)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;

  typedef struct packed {
    logic [4:0]  cause;
    logic [1:0]  code;
    logic [31:0] msr;
    logic [31:0] nia;
    logic        crit;
    logic [31:0] saddr;
    logic [31:0] sstate;
    logic [31:0] nmsr;
  } row_t;

  localparam int NROWS = 16;
  localparam logic [31:0] BASE = 32'hFFF0_0000;

  localparam row_t ROWS [NROWS] = '{
    '{5'd5,  2'd0, 32'h0000_9032, 32'h0000_2000, 1'b0, 32'h0000_2000, 32'h0000_9032, 32'h0000_1000},
    '{5'd6,  2'd0, 32'hFFFF_FFFF, 32'h1000_0104, 1'b0, 32'h1000_0100, 32'h87C0_FFFF, 32'h0000_1001},
    '{5'd7,  2'd1, 32'h0001_0000, 32'h0000_0400, 1'b0, 32'h0000_03FC, 32'h0008_0000, 32'h0000_0001},
    '{5'd7,  2'd2, 32'h0000_1000, 32'h0000_0800, 1'b0, 32'h0000_07FC, 32'h0004_1000, 32'h0000_1000},
    '{5'd7,  2'd3, 32'h0000_0000, 32'h0000_0010, 1'b0, 32'h0000_000C, 32'h0002_0000, 32'h0000_0000},
    '{5'd7,  2'd0, 32'h0000_3800, 32'h0000_0500, 1'b0, 32'h0000_04FC, 32'h0011_3800, 32'h0000_1000},
    '{5'd7,  2'd0, 32'h0000_2900, 32'h0000_0600, 1'b0, 32'h0000_0600, 32'h0010_2900, 32'h0000_0000},
    '{5'd2,  2'd0, 32'h0000_1000, 32'h0000_0700, 1'b1, 32'h0000_0700, 32'h0000_1000, 32'h0000_1000},
    '{5'd13, 2'd0, 32'h0003_0000, 32'h0000_0900, 1'b1, 32'h0000_0900, 32'h0000_0000, 32'h0000_0001},
    '{5'd0,  2'd0, 32'h0004_1000, 32'h0000_0A00, 1'b0, 32'h0000_0A00, 32'h0001_1000, 32'h0000_1000},
    '{5'd0,  2'd0, 32'h0000_1000, 32'h0000_0B00, 1'b0, 32'h0000_0B00, 32'h0000_1000, 32'h0000_0000},
    '{5'd1,  2'd0, 32'h0000_1000, 32'h0000_0C00, 1'b0, 32'h0000_0C00, 32'h0000_1000, 32'h0000_0000},
    '{5'd8,  2'd0, 32'h0000_2000, 32'h0000_0D00, 1'b0, 32'h0000_0CFC, 32'h0000_2000, 32'h0000_0000},
    '{5'd9,  2'd0, 32'h0000_1000, 32'h0000_0E00, 1'b0, 32'h0000_0E00, 32'h0000_1000, 32'h0000_1000},
    '{5'd16, 2'd0, 32'h0000_0000, 32'h0000_0F00, 1'b0, 32'h0000_0EFC, 32'h0000_0000, 32'h0000_0000},
    '{5'd10, 2'd0, 32'h0000_0000, 32'h0000_1100, 1'b0, 32'h0000_10FC, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [4:0]  req_cause = '0;
  logic [1:0]  req_code = '0;
  logic [31:0] cur_nia = '0;
  logic [31:0] cur_msr = '0;
  logic        ret_valid = 1'b0;
  logic        ret_crit = 1'b0;
  logic [31:0] vec_base = BASE;
  logic        vec_we = 1'b0;
  logic [4:0]  vec_idx = '0;
  logic [31:0] vec_wdata = '0;
  logic        redir_valid, msr_we, checkstop, vec_err;
  logic [31:0] redir_addr, msr_out;
  logic [31:0] nrm_ret_addr, nrm_ret_state, crt_ret_addr, crt_ret_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_entry_seq #(.XLEN(32)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cause(req_cause),
    .req_code(req_code), .cur_nia(cur_nia), .cur_msr(cur_msr),
    .ret_valid(ret_valid), .ret_crit(ret_crit), .vec_base(vec_base),
    .vec_we(vec_we), .vec_idx(vec_idx), .vec_wdata(vec_wdata),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .msr_we(msr_we),
    .msr_out(msr_out), .nrm_ret_addr(nrm_ret_addr), .nrm_ret_state(nrm_ret_state),
    .crt_ret_addr(crt_ret_addr), .crt_ret_state(crt_ret_state),
    .checkstop(checkstop), .vec_err(vec_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one request for one clock, then return at the next falling edge
  task automatic do_req(input logic [4:0] c, input logic [1:0] k,
                        input logic [31:0] m, input logic [31:0] n);
    req_valid = 1'b1; req_cause = c; req_code = k; cur_msr = m; cur_nia = n;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_ret(input logic crit);
    ret_valid = 1'b1; ret_crit = crit;
    @(negedge clk);
    ret_valid = 1'b0; ret_crit = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] n_a, n_s, c_a, c_s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "redir_valid", {31'd0, redir_valid}, 32'd0);
    chk("R1", "msr_we", {31'd0, msr_we}, 32'd0);
    chk("R1", "checkstop", {31'd0, checkstop}, 32'd0);
    chk("R1", "vec_err", {31'd0, vec_err}, 32'd0);
    chk("R1", "nrm_ret_addr", nrm_ret_addr, 32'd0);
    chk("R1", "crt_ret_state", crt_ret_state, 32'd0);

    for (int c = 0; c < 18; c++) begin
      vec_we = 1'b1; vec_idx = 5'(c); vec_wdata = 32'(c) << 8;
      @(negedge clk);
    end
    vec_we = 1'b1; vec_idx = 5'd20; vec_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    vec_we = 1'b0;

    // R2 R3 R4 R5 R7 R8 R9 table walk
    for (int i = 0; i < NROWS; i++) begin
      n_a = nrm_ret_addr; n_s = nrm_ret_state;
      c_a = crt_ret_addr; c_s = crt_ret_state;
      do_req(ROWS[i].cause, ROWS[i].code, ROWS[i].msr, ROWS[i].nia);
      chk("R2", "redir_valid", {31'd0, redir_valid}, 32'd1);
      chk("R2", "redir_addr", redir_addr, BASE | (32'(ROWS[i].cause) << 8));
      chk("R5", "msr_out", msr_out, ROWS[i].nmsr);
      if (ROWS[i].crit) begin
        chk("R3", "crit saved addr", crt_ret_addr, ROWS[i].saddr);
        chk("R4", "crit saved state", crt_ret_state, ROWS[i].sstate);
        chk("R7", "normal pair kept", nrm_ret_addr ^ nrm_ret_state, n_a ^ n_s);
      end else begin
        chk("R3", "saved addr", nrm_ret_addr, ROWS[i].saddr);
        chk("R4", "saved state", nrm_ret_state, ROWS[i].sstate);
        chk("R7", "crit pair kept", crt_ret_addr ^ crt_ret_state, c_a ^ c_s);
      end
      @(negedge clk);
      chk("R2", "pulse ends", {31'd0, redir_valid}, 32'd0);
    end

    // R6 FP drops
    n_a = nrm_ret_addr; n_s = nrm_ret_state;
    do_req(5'd7, 2'd0, 32'h0000_0900, 32'h0000_7000);
    chk("R6", "fp off drop redir", {31'd0, redir_valid}, 32'd0);
    chk("R6", "fp off drop save", nrm_ret_addr, n_a);
    do_req(5'd7, 2'd0, 32'h0000_2000, 32'h0000_7100);
    chk("R6", "fe both 0 drop redir", {31'd0, redir_valid}, 32'd0);
    chk("R6", "fe both 0 drop save", nrm_ret_state, n_s);

    // R10 normal return
    do_req(5'd5, 2'd0, 32'hFFFF_FFFF, 32'h0000_1237);
    do_ret(1'b0);
    chk("R10", "ret redir", {31'd0, redir_valid}, 32'd1);
    chk("R10", "ret addr", redir_addr, 32'h0000_1234);
    chk("R10", "ret state", msr_out, 32'h87C0_FFFF);
    chk("R10", "save kept", nrm_ret_addr, 32'h0000_1237);

    // R11 critical return
    do_req(5'd2, 2'd0, 32'hFFFF_FFFF, 32'h0000_2223);
    do_ret(1'b1);
    chk("R11", "ret addr", redir_addr, 32'h0000_2220);
    chk("R11", "ret state", msr_out, 32'h0000_FFFF);

    // R13 request wins over return
    ret_valid = 1'b1;
    do_req(5'd5, 2'd0, 32'h0000_0000, 32'h0000_3000);
    ret_valid = 1'b0;
    chk("R13", "redir addr", redir_addr, BASE | 32'h0000_0500);
    chk("R13", "saved addr", nrm_ret_addr, 32'h0000_3000);

    // R12 missing vector
    n_a = nrm_ret_addr;
    do_req(5'd20, 2'd0, 32'h0000_0000, 32'h0000_4000);
    chk("R12", "no redir", {31'd0, redir_valid}, 32'd0);
    chk("R12", "vec_err", {31'd0, vec_err}, 32'd1);
    chk("R12", "save kept", nrm_ret_addr, n_a);
    do_req(5'd5, 2'd0, 32'h0000_0000, 32'h0000_4100);
    chk("R12", "later redir", {31'd0, redir_valid}, 32'd1);
    chk("R12", "vec_err sticky", {31'd0, vec_err}, 32'd1);

    // R8 machine check with enable clear
    n_a = nrm_ret_addr;
    do_req(5'd1, 2'd0, 32'h0000_0000, 32'h0000_5000);
    chk("R8", "checkstop", {31'd0, checkstop}, 32'd1);
    chk("R8", "no redir", {31'd0, redir_valid}, 32'd0);
    do_req(5'd5, 2'd0, 32'h0000_0000, 32'h0000_5100);
    chk("R8", "req ignored", {31'd0, redir_valid}, 32'd0);
    chk("R8", "save kept", nrm_ret_addr, n_a);
    do_ret(1'b0);
    chk("R8", "ret ignored", {31'd0, msr_we}, 32'd0);
    chk("R8", "still stopped", {31'd0, checkstop}, 32'd1);

    // R1 reset clears sticky flags
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", "checkstop cleared", {31'd0, checkstop}, 32'd0);
    chk("R1", "vec_err cleared", {31'd0, vec_err}, 32'd0);
    chk("R1", "save cleared", nrm_ret_addr, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule